// File: doc/BRIEF.md
# Indexed-Port Real-Time Clock

This block is a battery-backed style real-time clock with general-purpose byte storage. A host reaches it through two pairs of byte-wide ports. On each pair, a write to the even port selects a register index and the odd port then transfers data in either direction. The lower pair reaches the lower 128-byte bank, which holds the time, alarm and control registers and then free RAM. The upper pair reaches a second 128-byte bank that is all RAM.

Time is kept in packed BCD: seconds, minutes, 24-hour hours, a weekday count from 1 to 7, date, month and a two-digit year. A `tickEn` pulse stands in for the divided crystal. Every `TICKS_PER_SEC` pulses the time takes one step, and carries ripple through the whole calendar in that one cycle, with leap Februaries taken into account. Software stops the step with a freeze bit while it loads a new time. A status bit warns that a step is near. Two event flags, one for the step and one for the alarm, clear when they are read.

Top module: `cmos_clock`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 01, date 01, month 01, year 00, and all three alarm bytes read 00. Control byte A reads 0x26 (bit 7 clear), control byte B reads 0x02, the flag byte reads 0x00, and the validity byte reads 0x80.
- R2: `busAddr` 0 latches a lower-bank index from `busWrData[6:0]` and `busAddr` 1 is its data port. `busAddr` 2 and 3 do the same for the upper bank. A read strobe on a data port loads `busRdData` at that clock edge. Indices 0x0E to 0x7F of the lower bank and every index of the upper bank are RAM bytes that return what was last written, and the two banks are separate.
- R3: The lower-bank indices are as follows. Seconds is 0x00, minutes 0x02, hours 0x04, weekday 0x06, date 0x07, month 0x08 and year 0x09. The seconds alarm is 0x01, the minutes alarm 0x03 and the hours alarm 0x05. Control A is 0x0A, control B 0x0B, the flag byte 0x0C and the validity byte 0x0D. Each time and alarm byte reads back the value written to it.
- R4: When control B bit 7 is clear, every `TICKS_PER_SEC`-th `tickEn` pulse steps the time once. Seconds go 59 to 00 and carry into minutes. Minutes go 59 to 00 and carry into hours. Hours go 23 to 00 and carry into the day.
- R5: A day carry moves the weekday from 7 to 1 and otherwise up by one. It also advances the date. The date rolls back to 01 after 30 in April, June, September and November and after 31 in the other long months. In February it rolls after 29 when the year is a multiple of 4 and after 28 otherwise, and carries into the month. The month goes 12 to 01 and carries into the year, which goes 99 to 00.
- R6: While control B bit 7 is set, no time byte changes except by a host write. Once the bit is cleared, stepping resumes.
- R7: Control A bit 7 reads 1 when B bit 7 is clear and the prescaler has reached its last `UIP_LEAD` counts before a step. It reads 0 otherwise and drops with the step. Host writes reach only bits 6:0 of A.
- R8: Flag byte bit 4 is set by every step. Bit 5 is set by a step after which seconds, minutes and hours equal their alarm bytes. The other flag bits read 0. A read of the flag byte returns the flags and then clears them, except that a flag set in the same cycle survives. Host writes to the flag byte have no effect.
- R9: The validity byte always reads 0x80, and host writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One pulse per time-base period |
| busAddr | input | 2 | Port select: 0/1 lower index/data, 2/3 upper index/data |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe (data ports only) |
| busWrData | input | 8 | Host write data or index |
| busRdData | output | 8 | Read data, loaded at the edge of a data-port read |

## Verification
The seconds-wrap assertion relies on the host loading time bytes with valid packed BCD, and the frozen-time assertion relies on time changing only through a step or a host write. The bench therefore writes only legal BCD values. It loads the time either with the tick stopped or with the freeze bit set, so a load never lands on a step cycle. The bench never raises the read and write strobes together.

// File: rtl/cmos_clock_pkg.sv
package cmos_clock_pkg;

  localparam int IDX_W      = 7;
  localparam int DATA_W     = 8;
  localparam int NUM_FIELDS = 7;
  localparam int NUM_ALARMS = 3;

  // field slots inside the time array
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_WDAY = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam logic [IDX_W-1:0] FIELD_IDX [NUM_FIELDS] =
    '{7'h00, 7'h02, 7'h04, 7'h06, 7'h07, 7'h08, 7'h09};
  localparam logic [DATA_W-1:0] FIELD_RST [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [IDX_W-1:0] ALARM_IDX [NUM_ALARMS] =
    '{7'h01, 7'h03, 7'h05};

  localparam logic [IDX_W-1:0] IX_CTLA  = 7'h0A;
  localparam logic [IDX_W-1:0] IX_CTLB  = 7'h0B;
  localparam logic [IDX_W-1:0] IX_FLAGS = 7'h0C;
  localparam logic [IDX_W-1:0] IX_VALID = 7'h0D;
  localparam logic [IDX_W-1:0] RAM_BASE = 7'h0E;

  localparam logic [DATA_W-2:0] CTLA_RST   = 7'h26;
  localparam logic [DATA_W-1:0] CTLB_RST   = 8'h02;
  localparam logic [DATA_W-1:0] VALID_BYTE = 8'h80;
  localparam int FREEZE_BIT    = 7;
  localparam int FLAG_UPD_BIT  = 4;
  localparam int FLAG_ALRM_BIT = 5;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              hiBank;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wrData;
    logic              step;
    logic              uip;
  } ctrlStr_t;

  function automatic logic [7:0] bcdIncr(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcdRoll(input logic [7:0] v,
                                         input logic [7:0] top,
                                         input logic [7:0] bottom);
    return (v == top) ? bottom : bcdIncr(v);
  endfunction

  // 10*t+u mod 4 equals 2*t+u mod 4
  function automatic logic isLeap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] m,
                                           input logic [7:0] y);
    case (m)
      8'h02:                      return isLeap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cmos_clock_ctrl.sv
module cmos_clock_ctrl
  import cmos_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              freezeOn,
  output ctrlStr_t          ctrlStr
);

  localparam int CNT_W = $clog2(TICKS_PER_SEC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] UIP_START = CNT_W'(TICKS_PER_SEC - UIP_LEAD);

  logic [CNT_W-1:0] divCnt;
  logic [IDX_W-1:0] idxLo;
  logic [IDX_W-1:0] idxHi;
  logic             idxWr;
  logic             atLast;

  assign idxWr  = busWr && !busAddr[0];
  assign atLast = (divCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxLo <= '0;
      idxHi <= '0;
    end else if (idxWr) begin
      if (busAddr[1]) idxHi <= busWrData[IDX_W-1:0];
      else            idxLo <= busWrData[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       divCnt <= '0;
    else if (tickEn) divCnt <= atLast ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    ctrlStr.wrEn   = busWr && busAddr[0];
    ctrlStr.rdEn   = busRd && busAddr[0];
    ctrlStr.hiBank = busAddr[1];
    ctrlStr.idx    = busAddr[1] ? idxHi : idxLo;
    ctrlStr.wrData = busWrData;
    ctrlStr.step   = tickEn && atLast && !freezeOn;
    ctrlStr.uip    = !freezeOn && (divCnt >= UIP_START);
  end

endmodule

// File: rtl/cmos_clock_dp.sv
module cmos_clock_dp
  import cmos_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStr_t          ctrlStr,
  output logic [DATA_W-1:0] busRdData,
  output logic              freezeOn,
  output logic [DATA_W-1:0] timeSec,
  output logic [DATA_W-1:0] flagsC
);

  localparam int RAM_DEPTH = 2 ** (IDX_W + 1);

  logic [DATA_W-1:0] tf       [NUM_FIELDS];
  logic [DATA_W-1:0] tfNx     [NUM_FIELDS];
  logic [DATA_W-1:0] alarmReg [NUM_ALARMS];
  logic [DATA_W-1:0] ramMem   [RAM_DEPTH];
  logic [DATA_W-2:0] ctlA;
  logic [DATA_W-1:0] ctlB;
  logic              alarmFlag;
  logic              updFlag;

  logic [NUM_FIELDS-1:0] fieldHit;
  logic [NUM_ALARMS-1:0] alarmHitIdx;
  logic                  lowSel;
  logic                  lowWr;
  logic                  flagRead;
  logic                  alarmMatch;
  logic                  secCy, minCy, dayCy, monCy, yrCy;
  logic [DATA_W-1:0]     dateLast;
  logic [DATA_W-1:0]     rdMux;

  assign lowSel   = !ctrlStr.hiBank;
  assign lowWr    = ctrlStr.wrEn && lowSel;
  assign flagRead = ctrlStr.rdEn && lowSel && (ctrlStr.idx == IX_FLAGS);
  assign freezeOn = ctlB[FREEZE_BIT];
  assign timeSec  = tf[F_SEC];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gFieldHit
    assign fieldHit[g] = lowSel && (ctrlStr.idx == FIELD_IDX[g]);
  end
  for (genvar g = 0; g < NUM_ALARMS; g++) begin : gAlarmHit
    assign alarmHitIdx[g] = lowSel && (ctrlStr.idx == ALARM_IDX[g]);
  end

  // calendar carry chain, resolved in one cycle
  always_comb begin
    secCy    = (tf[F_SEC] == 8'h59);
    minCy    = secCy && (tf[F_MIN] == 8'h59);
    dayCy    = minCy && (tf[F_HR] == 8'h23);
    dateLast = monthLast(tf[F_MON], tf[F_YEAR]);
    monCy    = dayCy && (tf[F_DATE] == dateLast);
    yrCy     = monCy && (tf[F_MON] == 8'h12);

    tfNx[F_SEC]  = bcdRoll(tf[F_SEC], 8'h59, 8'h00);
    tfNx[F_MIN]  = secCy ? bcdRoll(tf[F_MIN], 8'h59, 8'h00) : tf[F_MIN];
    tfNx[F_HR]   = minCy ? bcdRoll(tf[F_HR], 8'h23, 8'h00) : tf[F_HR];
    tfNx[F_WDAY] = dayCy ? bcdRoll(tf[F_WDAY], 8'h07, 8'h01) : tf[F_WDAY];
    tfNx[F_DATE] = dayCy ? bcdRoll(tf[F_DATE], dateLast, 8'h01) : tf[F_DATE];
    tfNx[F_MON]  = monCy ? bcdRoll(tf[F_MON], 8'h12, 8'h01) : tf[F_MON];
    tfNx[F_YEAR] = yrCy ? bcdRoll(tf[F_YEAR], 8'h99, 8'h00) : tf[F_YEAR];

    alarmMatch = (tfNx[F_SEC] == alarmReg[0]) &&
                 (tfNx[F_MIN] == alarmReg[1]) &&
                 (tfNx[F_HR]  == alarmReg[2]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_FIELDS; g++) tf[g] <= FIELD_RST[g];
    end else begin
      for (int g = 0; g < NUM_FIELDS; g++) begin
        if (ctrlStr.wrEn && fieldHit[g]) tf[g] <= ctrlStr.wrData;
        else if (ctrlStr.step)           tf[g] <= tfNx[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_ALARMS; g++) alarmReg[g] <= '0;
      ctlA <= CTLA_RST;
      ctlB <= CTLB_RST;
    end else begin
      for (int g = 0; g < NUM_ALARMS; g++)
        if (ctrlStr.wrEn && alarmHitIdx[g]) alarmReg[g] <= ctrlStr.wrData;
      if (lowWr && ctrlStr.idx == IX_CTLA) ctlA <= ctrlStr.wrData[DATA_W-2:0];
      if (lowWr && ctrlStr.idx == IX_CTLB) ctlB <= ctrlStr.wrData;
    end
  end

  // a flag raised in the cycle of a read is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updFlag   <= 1'b0;
      alarmFlag <= 1'b0;
    end else begin
      if (ctrlStr.step)   updFlag <= 1'b1;
      else if (flagRead)  updFlag <= 1'b0;
      if (ctrlStr.step && alarmMatch) alarmFlag <= 1'b1;
      else if (flagRead)              alarmFlag <= 1'b0;
    end
  end

  always_comb begin
    flagsC                = '0;
    flagsC[FLAG_UPD_BIT]  = updFlag;
    flagsC[FLAG_ALRM_BIT] = alarmFlag;
  end

  always_ff @(posedge clk) begin
    if (ctrlStr.wrEn && (ctrlStr.hiBank || ctrlStr.idx >= RAM_BASE))
      ramMem[{ctrlStr.hiBank, ctrlStr.idx}] <= ctrlStr.wrData;
  end

  always_comb begin
    rdMux = ramMem[{ctrlStr.hiBank, ctrlStr.idx}];
    for (int g = 0; g < NUM_FIELDS; g++)
      if (fieldHit[g]) rdMux = tf[g];
    for (int g = 0; g < NUM_ALARMS; g++)
      if (alarmHitIdx[g]) rdMux = alarmReg[g];
    if (lowSel) begin
      case (ctrlStr.idx)
        IX_CTLA:  rdMux = {ctrlStr.uip, ctlA};
        IX_CTLB:  rdMux = ctlB;
        IX_FLAGS: rdMux = flagsC;
        IX_VALID: rdMux = VALID_BYTE;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busRdData <= '0;
    else if (ctrlStr.rdEn) busRdData <= rdMux;
  end

endmodule

// File: rtl/cmos_clock.sv
module cmos_clock
  import cmos_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [1:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData
);

  ctrlStr_t          ctrlStr;
  logic              freezeOn;
  logic [DATA_W-1:0] timeSec;
  logic [DATA_W-1:0] flagsC;

  cmos_clock_ctrl #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .UIP_LEAD      (UIP_LEAD)
  ) ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .busWrData (busWrData),
    .freezeOn  (freezeOn),
    .ctrlStr   (ctrlStr)
  );

  cmos_clock_dp dpI (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlStr   (ctrlStr),
    .busRdData (busRdData),
    .freezeOn  (freezeOn),
    .timeSec   (timeSec),
    .flagsC    (flagsC)
  );

endmodule

// File: rtl/cmos_clock_chk.sv
module cmos_clock_chk
  import cmos_clock_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input ctrlStr_t          ctrlStr,
  input logic              freezeOn,
  input logic [DATA_W-1:0] timeSec,
  input logic [DATA_W-1:0] flagsC,
  input logic [DATA_W-1:0] busRdData
);

  logic secWrite;
  logic flagRead;
  logic validRead;

  assign secWrite  = ctrlStr.wrEn && !ctrlStr.hiBank && (ctrlStr.idx == FIELD_IDX[F_SEC]);
  assign flagRead  = ctrlStr.rdEn && !ctrlStr.hiBank && (ctrlStr.idx == IX_FLAGS);
  assign validRead = ctrlStr.rdEn && !ctrlStr.hiBank && (ctrlStr.idx == IX_VALID);

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStr.step && timeSec == 8'h59 && !secWrite) |=> (timeSec == 8'h00)); // R4

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (freezeOn && !secWrite) |=> $stable(timeSec)); // R6

  AST_UIP_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStr.step |=> !ctrlStr.uip); // R7

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !ctrlStr.step) |=> (flagsC == 8'h00)); // R8

  AST_VALID_CONST: assert property (@(posedge clk) disable iff (!rstN)
    validRead |=> (busRdData == 8'h80)); // R9

endmodule

bind cmos_clock cmos_clock_chk chkI (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlStr   (ctrlStr),
  .freezeOn  (freezeOn),
  .timeSec   (timeSec),
  .flagsC    (flagsC),
  .busRdData (busRdData)
);

// File: tb/cmos_clock_tb_top.sv
`timescale 1ns/1ps
module cmos_clock_tb_top;

  localparam int TPS  = 16;
  localparam int LEAD = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic [1:0] busAddr;
  logic       busWr;
  logic       busRd;
  logic [7:0] busWrData;
  logic [7:0] busRdData;

  int    checks = 0;
  int    errors = 0;
  int    tickMode = 0;
  bit    finished = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  cmos_clock #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWrData(busWrData), .busRdData(busRdData)
  );

  // ---------------- reference model ----------------
  int         mCnt, mSec, mMin, mHr, mWday, mDate, mMon, mYear;
  logic [7:0] mAS, mAM, mAH, mB;
  logic [6:0] mA, mIdxLo, mIdxHi;
  bit         mAf, mUf, mRdValid;
  logic [7:0] mRd;
  logic [7:0] mRam [256];

  function automatic logic [7:0] toBcd(int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int fromBcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int monLen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] modelRead(bit hi, int idx);
    if (hi) return mRam[128 + idx];
    if (idx >= 14) return mRam[idx];
    case (idx)
      0: return toBcd(mSec);
      1: return mAS;
      2: return toBcd(mMin);
      3: return mAM;
      4: return toBcd(mHr);
      5: return mAH;
      6: return toBcd(mWday);
      7: return toBcd(mDate);
      8: return toBcd(mMon);
      9: return toBcd(mYear);
      10: return {(!mB[7] && (mCnt >= TPS - LEAD)), mA};
      11: return mB;
      12: return {2'b00, mAf, mUf, 4'h0};
      default: return 8'h80;
    endcase
  endfunction

  task automatic modelWrite(bit hi, int idx, logic [7:0] v);
    if (hi) mRam[128 + idx] = v;
    else if (idx >= 14) mRam[idx] = v;
    else case (idx)
      0: mSec = fromBcd(v);
      1: mAS = v;
      2: mMin = fromBcd(v);
      3: mAM = v;
      4: mHr = fromBcd(v);
      5: mAH = v;
      6: mWday = fromBcd(v);
      7: mDate = fromBcd(v);
      8: mMon = fromBcd(v);
      9: mYear = fromBcd(v);
      10: mA = v[6:0];
      11: mB = v;
      default: ;
    endcase
  endtask

  task automatic modelStep();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHr++;
        if (mHr == 24) begin
          mHr = 0;
          mWday = (mWday == 7) ? 1 : mWday + 1;
          if (mDate == monLen(mMon, mYear)) begin
            mDate = 1; mMon++;
            if (mMon == 13) begin mMon = 1; mYear = (mYear + 1) % 100; end
          end else mDate++;
        end
      end
    end
    mUf = 1;
    if (toBcd(mSec) == mAS && toBcd(mMin) == mAM && toBcd(mHr) == mAH) mAf = 1;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mSec = 0; mMin = 0; mHr = 0; mWday = 1; mDate = 1; mMon = 1; mYear = 0;
      mAS = 0; mAM = 0; mAH = 0; mA = 7'h26; mB = 8'h02; mAf = 0; mUf = 0;
      mIdxLo = 0; mIdxHi = 0; mRdValid = 0;
    end else begin
      bit hi;
      int idx;
      bit stepNow;
      hi = busAddr[1];
      idx = hi ? int'(mIdxHi) : int'(mIdxLo);
      mRdValid = 0;
      if (busRd && busAddr[0]) begin
        mRd = modelRead(hi, idx);
        mRdValid = 1;
        if (!hi && idx == 12) begin mAf = 0; mUf = 0; end
      end
      stepNow = 0;
      if (tickEn) begin
        if (mCnt == TPS - 1) begin mCnt = 0; stepNow = !mB[7]; end
        else mCnt++;
      end
      if (stepNow) modelStep();
      if (busWr) begin
        if (!busAddr[0]) begin
          if (hi) mIdxHi = busWrData[6:0]; else mIdxLo = busWrData[6:0];
        end else modelWrite(hi, idx, busWrData);
      end
    end
  end

  // compare after every read, away from the active edge
  always @(negedge clk) begin
    if (rstN && mRdValid) begin
      checks++;
      if (busRdData !== mRd) begin
        errors++;
        $display("FAIL %s: read data actual %h expected %h at %0t", curTag, busRdData, mRd, $time);
      end
    end
  end

  always @(negedge clk) begin
    case (tickMode)
      0: tickEn <= 1'b0;
      1: tickEn <= 1'b1;
      default: tickEn <= ~tickEn;
    endcase
  end

  // ---------------- host access ----------------
  task automatic putReg(bit hi, logic [6:0] idx, logic [7:0] v);
    @(negedge clk); busAddr = hi ? 2'd2 : 2'd0; busWr = 1; busWrData = {1'b0, idx};
    @(negedge clk); busAddr = hi ? 2'd3 : 2'd1; busWrData = v;
    @(negedge clk); busWr = 0;
  endtask

  task automatic getReg(bit hi, logic [6:0] idx);
    @(negedge clk); busAddr = hi ? 2'd2 : 2'd0; busWr = 1; busWrData = {1'b0, idx};
    @(negedge clk); busWr = 0; busAddr = hi ? 2'd3 : 2'd1; busRd = 1;
    @(negedge clk); busRd = 0;
  endtask

  task automatic loadTime(logic [7:0] hr, logic [7:0] mn, logic [7:0] sc,
                          logic [7:0] wd, logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    putReg(0, 7'h04, hr); putReg(0, 7'h02, mn); putReg(0, 7'h00, sc);
    putReg(0, 7'h06, wd); putReg(0, 7'h07, dt); putReg(0, 7'h08, mo); putReg(0, 7'h09, yr);
  endtask

  task automatic readAll();
    for (int i = 0; i < 14; i++) getReg(0, 7'(i));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frozenLoadRun(logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    putReg(0, 7'h0B, 8'h82);
    loadTime(8'h23, 8'h59, 8'h59, 8'h03, dt, mo, yr);
    putReg(0, 7'h0B, 8'h02);
    idle(TPS + 4);
    getReg(0, 7'h07); getReg(0, 7'h08); getReg(0, 7'h09); getReg(0, 7'h06);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; busAddr = 0; busWr = 0; busRd = 0; busWrData = 0;
    idle(4);
    rstN = 1;
    idle(2);

    curTag = "R1";  // reset values
    readAll();

    curTag = "R2";  // both banks, separate RAM
    putReg(0, 7'h20, 8'hA5); putReg(1, 7'h20, 8'h5A);
    putReg(0, 7'h7F, 8'h3C); putReg(1, 7'h00, 8'hC3); putReg(0, 7'h0E, 8'h11);
    getReg(0, 7'h20); getReg(1, 7'h20); getReg(0, 7'h7F); getReg(1, 7'h00); getReg(0, 7'h0E);

    curTag = "R3";  // map, writes read back
    loadTime(8'h17, 8'h42, 8'h31, 8'h05, 8'h19, 8'h08, 8'h47);
    putReg(0, 7'h01, 8'h12); putReg(0, 7'h03, 8'h34); putReg(0, 7'h05, 8'h21);
    readAll();

    curTag = "R4";  // full carry chain into new year
    loadTime(8'h23, 8'h59, 8'h58, 8'h07, 8'h31, 8'h12, 8'h99);
    tickMode = 1;
    idle(2 * TPS + 2);
    tickMode = 0;
    curTag = "R5";
    readAll();

    tickMode = 1;
    curTag = "R5";  // leap, non-leap, short month
    frozenLoadRun(8'h28, 8'h02, 8'h24);
    frozenLoadRun(8'h28, 8'h02, 8'h23);
    frozenLoadRun(8'h29, 8'h02, 8'h00);
    frozenLoadRun(8'h30, 8'h04, 8'h10);
    frozenLoadRun(8'h30, 8'h05, 8'h10);

    curTag = "R6";  // freeze holds, load, resume
    putReg(0, 7'h0B, 8'h82);
    for (int i = 0; i < 5; i++) begin idle(TPS); getReg(0, 7'h00); getReg(0, 7'h02); end
    putReg(0, 7'h00, 8'h42);
    getReg(0, 7'h00);
    putReg(0, 7'h0B, 8'h02);
    idle(3 * TPS);
    getReg(0, 7'h00);

    curTag = "R7";  // update-in-progress sampling
    putReg(0, 7'h0A, 8'hFF);
    for (int i = 0; i < 24; i++) getReg(0, 7'h0A);
    tickMode = 2;
    for (int i = 0; i < 24; i++) getReg(0, 7'h0A);
    tickMode = 1;
    putReg(0, 7'h0B, 8'h82);
    for (int i = 0; i < 8; i++) getReg(0, 7'h0A);
    putReg(0, 7'h0B, 8'h02);

    curTag = "R8";  // alarm and clear-on-read
    putReg(0, 7'h0B, 8'h82);
    loadTime(8'h12, 8'h00, 8'h03, 8'h02, 8'h10, 8'h06, 8'h30);
    putReg(0, 7'h01, 8'h05); putReg(0, 7'h03, 8'h00); putReg(0, 7'h05, 8'h12);
    getReg(0, 7'h0C);
    putReg(0, 7'h0B, 8'h02);
    idle(2 * TPS + 4);
    getReg(0, 7'h0C); getReg(0, 7'h0C);
    putReg(0, 7'h0C, 8'hFF);
    getReg(0, 7'h0C);
    for (int i = 0; i < 40; i++) getReg(0, 7'h0C);

    curTag = "R9";  // validity byte
    putReg(0, 7'h0D, 8'h00);
    getReg(0, 7'h0D);
    tickMode = 0;
    idle(4);

    finished = 1;
    summary();
    $finish;
  end

endmodule